// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Guard

This block watches the shared open-drain data line on behalf of one bus master. It flags the moment that master loses the bus to another master. Arbitration is decided one bit at a time. At each rising edge of the synchronized clock line, the bit this master meant to put on SDA is compared with the level actually on the wire. Because the line is a wired-AND, a master that leaves SDA high while another pulls it low sees a 0 where it meant a 1, and it has lost.

Nothing in the comparison is tied to byte boundaries. Masters that send identical bytes keep being compared through the following bytes until one of them differs. As a result, the stream with the lowest binary value wins.

The master's bit engine supplies four inputs: the intended bit, a transmitting flag, a flag marking acknowledge slots driven by the receiver, and start/stop events seen on the bus. The block answers with three signals. The first is a one-cycle loss pulse. The second is a sticky loss flag that software clears by writing a one. The third is a pair of release commands: one tells the master to stop driving SDA at once, and the other tells it to stop driving SCL once the current low period is over.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset `lost_pulse`, `lost_flag`, `release_sda` and `release_scl` are all 0.
- R2: When armed, transmitting, outside an acknowledge slot, with `want_sda`=1 and the sampled SDA at 0 on an SCL rising edge, `lost_pulse` is 1 for exactly one cycle, SYNC_STAGES+1 clock edges after the SCL rise at the pins.
- R3: Bits whose sampled SDA equals `want_sda` never cause a loss, however many bytes in a row match.
- R4: `want_sda`=0 with SDA sampled at 1 is not a loss.
- R5: While `ack_slot`=1, no comparison takes place.
- R6: No comparison takes place while `tx_active`=0, or while the guard is unarmed. A `start_evt` arms the guard and a `stop_evt` disarms it; reset leaves it unarmed.
- R7: SDA counts only at the SCL rising edge. A mismatch while SCL is low, or one that appears later in the high period, has no effect.
- R8: `lost_flag` is set together with `lost_pulse`. It stays set through stop and start events and is cleared only by a `clear_lost` strobe or by reset.
- R9: `release_sda` rises in the same cycle as `lost_pulse` and holds until `stop_evt`.
- R10: `release_scl` rises on the first cycle after `release_sda` is set in which the synchronized SCL is high, and clears on `stop_evt`.
- R11: While released, further mismatches produce no pulse. After stop and a new start, comparison resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| want_sda | input | 1 | Bit this master intends on SDA |
| tx_active | input | 1 | Master is currently transmitting |
| ack_slot | input | 1 | Current bit is a receiver-driven acknowledge slot |
| start_evt | input | 1 | One-cycle start condition event |
| stop_evt | input | 1 | One-cycle stop condition event |
| clear_lost | input | 1 | Write-one-to-clear strobe for the sticky flag |
| lost_pulse | output | 1 | One-cycle arbitration-lost pulse |
| lost_flag | output | 1 | Sticky arbitration-lost flag |
| release_sda | output | 1 | Stop driving SDA |
| release_scl | output | 1 | Stop driving SCL |

## Verification
A stale rising-edge history or a wrong arm state shows up at the ports as a loss pulse missing or misplaced within one SCL bit time. The bench checks the pulse in the exact cycle that lies SYNC_STAGES+1 edges after the SCL rise, and checks that it has gone again on the next cycle. Errors in the latch logic of the release pair or the sticky flag show up as wrong levels on the cycle after a stop, a start or a clear strobe. The bench samples them right at that point.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
   // One sample of the two bus wires.
   typedef struct packed {
      logic scl;
      logic sda;
   } bus_lines_t;

   localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync
   import i2c_arb_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bus_lines_t d_in,
   output bus_lines_t q_out
);
   generate
      if (STAGES > 4) begin : g_bad_depth
         $error("i2c_arb_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         bus_lines_t chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= LINES_IDLE;
            end else begin
               chain[0] <= d_in;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_arb_judge.sv
module i2c_arb_judge
   import i2c_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  bus_lines_t lines,
   input  logic       enable,
   input  logic       tx_active,
   input  logic       ack_slot,
   input  logic       want_sda,
   output logic       scl_rise,
   output logic       hit
);
   logic scl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev <= 1'b1;
      else        scl_prev <= lines.scl;
   end

   assign scl_rise = lines.scl & ~scl_prev;

   // Lost: this master left SDA high but the wired-AND line reads low.
   always_comb begin
      hit = 1'b0;
      if (scl_rise && enable && tx_active && !ack_slot)
         hit = want_sda & ~lines.sda;
   end

   // R7: a rising edge can never be seen two cycles in a row.
   assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |=> !scl_rise);
endmodule

// File: rtl/i2c_arb_release.sv
module i2c_arb_release (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic scl_high,
   input  logic stop_evt,
   input  logic clear_lost,
   output logic lost_pulse,
   output logic lost_flag,
   output logic release_sda,
   output logic release_scl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_pulse  <= 1'b0;
         lost_flag   <= 1'b0;
         release_sda <= 1'b0;
         release_scl <= 1'b0;
      end else begin
         lost_pulse  <= hit;
         lost_flag   <= hit | (lost_flag & ~clear_lost);
         release_sda <= hit | (release_sda & ~stop_evt);
         release_scl <= ~stop_evt & (release_scl | (release_sda & scl_high));
      end
   end

   assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lost_pulse |=> !lost_pulse);
   assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lost_pulse |-> lost_flag);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_flag && !clear_lost) |=> lost_flag);
   assert_release_with_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lost_pulse |-> release_sda);
   assert_scl_after_sda_R10: assert property (@(posedge clk) disable iff (!rst_n)
      release_scl |-> release_sda);
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
   import i2c_arb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic want_sda,
   input  logic tx_active,
   input  logic ack_slot,
   input  logic start_evt,
   input  logic stop_evt,
   input  logic clear_lost,
   output logic lost_pulse,
   output logic lost_flag,
   output logic release_sda,
   output logic release_scl
);
   bus_lines_t raw_lines, sync_lines;
   logic       armed, enable, scl_rise, hit;

   assign raw_lines = '{scl: scl_in, sda: sda_in};

   i2c_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(raw_lines), .q_out(sync_lines));

   // Armed between a start and a stop event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (start_evt) armed <= 1'b1;
      else if (stop_evt)  armed <= 1'b0;
   end

   assign enable = armed & ~release_sda;

   i2c_arb_judge u_judge (
      .clk(clk), .rst_n(rst_n), .lines(sync_lines), .enable(enable),
      .tx_active(tx_active), .ack_slot(ack_slot), .want_sda(want_sda),
      .scl_rise(scl_rise), .hit(hit));

   i2c_arb_release u_release (
      .clk(clk), .rst_n(rst_n), .hit(hit), .scl_high(sync_lines.scl),
      .stop_evt(stop_evt), .clear_lost(clear_lost),
      .lost_pulse(lost_pulse), .lost_flag(lost_flag),
      .release_sda(release_sda), .release_scl(release_scl));

   // R11: no new loss while already released.
   assert_no_pulse_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      release_sda |=> !lost_pulse);
   // R2: every pulse follows an SCL rising edge one cycle earlier.
   assert_pulse_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> lost_pulse);
   // R6: nothing is judged while unarmed.
   assert_no_hit_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !lost_pulse);
endmodule

// File: tb/i2c_arb_guard_test.sv
module i2c_arb_guard_test;
   localparam int SYNC = 2;
   localparam int NVEC = 18;
   // Each entry: {tx_active, ack_slot, want_sda, sda, expect_loss}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b10110, 5'b10000, 5'b10110, 5'b10000, 5'b10000, 5'b10110, 5'b10000, 5'b10110,
      5'b11100, 5'b10000, 5'b10110, 5'b10010, 5'b10110, 5'b10000,
      5'b00100, 5'b10101, 5'b10000, 5'b10101};

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_in = 1'b1, sda_in = 1'b1, want_sda = 1'b1, tx_active = 1'b0, ack_slot = 1'b0;
   logic start_evt = 1'b0, stop_evt = 1'b0, clear_lost = 1'b0;
   logic lost_pulse, lost_flag, release_sda, release_scl;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2c_arb_guard #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .want_sda(want_sda),
      .tx_active(tx_active), .ack_slot(ack_slot), .start_evt(start_evt),
      .stop_evt(stop_evt), .clear_lost(clear_lost), .lost_pulse(lost_pulse),
      .lost_flag(lost_flag), .release_sda(release_sda), .release_scl(release_scl));

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic strobe(ref logic sig);
      sig = 1'b1; @(negedge clk); sig = 1'b0; @(negedge clk);
   endtask

   // One bit: low phase, then rise; sample pulse SYNC+1 edges after the rise.
   task automatic do_bit(input logic w, input logic s, input logic exp, input string tag);
      scl_in = 1'b0; want_sda = w; sda_in = s;
      repeat (SYNC + 1) @(negedge clk);
      scl_in = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      check(lost_pulse == exp, tag, "lost_pulse", lost_pulse, exp);
      if (exp) begin
         check(release_sda == 1'b1, "R9", "release_sda", release_sda, 1);
         check(lost_flag == 1'b1, "R8", "lost_flag", lost_flag, 1);
      end
      @(negedge clk);
      check(lost_pulse == 1'b0, "R2", "pulse width", lost_pulse, 0);
      if (exp) check(release_scl == 1'b1, "R10", "release_scl", release_scl, 1);
   endtask

   task automatic recover();
      strobe(stop_evt);
      check(release_sda == 1'b0, "R9", "release_sda after stop", release_sda, 0);
      check(release_scl == 1'b0, "R10", "release_scl after stop", release_scl, 0);
      check(lost_flag == 1'b1, "R8", "flag kept over stop", lost_flag, 1);
      strobe(clear_lost);
      check(lost_flag == 1'b0, "R8", "flag after clear", lost_flag, 0);
      strobe(start_evt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(lost_pulse == 0 && lost_flag == 0 && release_sda == 0 && release_scl == 0,
            "R1", "outputs in reset", {lost_pulse, lost_flag, release_sda, release_scl}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({lost_pulse, lost_flag, release_sda, release_scl} == 4'b0, "R1",
            "outputs after reset", {lost_pulse, lost_flag, release_sda, release_scl}, 0);

      // R6: unarmed, mismatch ignored.
      tx_active = 1'b1;
      do_bit(1'b1, 1'b0, 1'b0, "R6 unarmed");
      check(lost_flag == 1'b0, "R6", "flag unarmed", lost_flag, 0);

      strobe(start_evt);
      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tx_active = VEC[i][4]; ack_slot = VEC[i][3];
         if (VEC[i][0])                      tag = "R2 loss";
         else if (VEC[i][3])                 tag = "R5 ack";
         else if (!VEC[i][4])                tag = "R6 idle";
         else if (!VEC[i][2] && VEC[i][1])   tag = "R4 0vs1";
         else                                tag = "R3 match";
         do_bit(VEC[i][2], VEC[i][1], VEC[i][0], tag);
         ack_slot = 1'b0; tx_active = 1'b1;
         if (VEC[i][0]) begin
            // R11: still released, no new pulse.
            do_bit(1'b1, 1'b0, 1'b0, "R11 released");
            check(lost_flag == 1'b1, "R11", "flag held", lost_flag, 1);
            recover();
         end
      end

      // R7: mismatch only while SCL low, and after the rise while high.
      scl_in = 1'b0; want_sda = 1'b1; sda_in = 1'b0;
      repeat (4) @(negedge clk);
      sda_in = 1'b1; @(negedge clk);
      scl_in = 1'b1; repeat (2) @(negedge clk);
      sda_in = 1'b0; repeat (5) @(negedge clk);
      check(lost_flag == 1'b0, "R7", "flag after off-edge mismatch", lost_flag, 0);
      check(release_sda == 1'b0, "R7", "release after off-edge", release_sda, 0);

      // R6: stop disarms.
      strobe(stop_evt);
      do_bit(1'b1, 1'b0, 1'b0, "R6 after stop");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule